// File: doc/BRIEF.md
# Set/Clear GPIO Register Block

A memory-mapped general-purpose I/O block with a 32-bit data path that accepts full-word accesses only. It holds a pin level register and a direction register (1 = output). Software changes pin levels with write-only set and clear strobes, so no read-modify-write is needed. The level register drives the output pins at all times.

A set or clear strobe is accepted only if the written value selects at least one pin configured as output. A strobe that selects only input pins is dropped whole and raises a sticky error flag. Three edge-detect configuration addresses accept writes but change nothing. One spare general-purpose word register is available at offset 0x20. Interrupt generation is not implemented, and every interrupt group output stays low.

Reads are combinational from the current register state. A write takes effect on the rising clock edge on which `req_i`, `we_i` and all four byte enables are high.

Top module: `gpio_setclr_regs`

## Requirements
- R1: After reset the level register, the direction register, the general-purpose register and the error flag are all zero.
- R2: Offset 0x04 holds the direction register. A full-word write stores the value, and a read at 0x04 returns it on `rdata_o` and on `dir_o`.
- R3: A full-word write to offset 0x08, when (direction AND data) is non-zero, ORs all written bits (input bits included) into the level register on that clock edge.
- R4: A full-word write to offset 0x0C, when (direction AND data) is non-zero, clears the written bits in the level register on that clock edge.
- R5: A set or clear write with (direction AND data) equal to zero leaves the level register unchanged. It sets `err_o`, which stays high until reset.
- R6: Writes to offsets 0x10, 0x14 and 0x18 change no register. Reads of offsets 0x08 through 0x18 return 0.
- R7: Offset 0x20 is a 32-bit register that reads back the last value written to it.
- R8: Writes to offset 0x00 and to undefined offsets change no register. Reads of undefined offsets return 0.
- R9: A write with any byte enable (`be_i`, 4 bits, bit n covering data byte n) low is ignored as a whole and does not set `err_o`.
- R10: `pin_o` always equals the level register. Every bit of `irq_o` is always 0.
- R11: A read at offset 0x00 returns the level register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte enables; all four must be high for a write |
| addr_i | input | AW (12) | Byte address |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data, combinational |
| pin_o | output | DW (32) | Pin levels driven from the level register |
| dir_o | output | DW (32) | Direction register, 1 = output |
| err_o | output | 1 | Sticky flag for dropped set/clear writes |
| irq_o | output | IRQ_N (9) | Interrupt group outputs, always 0 |

## Verification
The bench writes set and clear values that overlap output pins only partly. If the acceptance test were applied per bit instead of to the whole value, the input bits of an accepted set would be missing from the level register. It sends set and clear writes that touch only input pins. A design without the rejection would change the level, and one without the sticky flag would leave `err_o` low or let it drop again. It also writes to the edge-detect addresses, to offset 0x00, to undefined offsets and with partial byte enables. A design that decoded any of these as a register write would show changed direction, level or general-purpose contents, or would raise the error flag when it should not.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  localparam int unsigned OFF_LVL  = 'h00;
  localparam int unsigned OFF_DIR  = 'h04;
  localparam int unsigned OFF_SET  = 'h08;
  localparam int unsigned OFF_CLR  = 'h0C;
  localparam int unsigned OFF_RISE = 'h10;
  localparam int unsigned OFF_FALL = 'h14;
  localparam int unsigned OFF_EDGE = 'h18;
  localparam int unsigned OFF_GP   = 'h20;

  typedef struct packed {
    logic lvl_set;
    logic lvl_clr;
    logic dir;
    logic gp;
  } wr_sel_t;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_LVL  = 2'd1,
    RD_DIR  = 2'd2,
    RD_GP   = 2'd3
  } rd_src_e;
endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
  import gpio_sc_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned BW = 4
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [BW-1:0] be_i,
  input  logic [AW-1:0] addr_i,
  output wr_sel_t       wr_o,
  output rd_src_e       rd_o
);
  logic wr_ok;
  assign wr_ok = req_i & we_i & (&be_i);

  // edge-detect offsets and 0x00 decode to no write target
  always_comb begin
    wr_o         = '0;
    wr_o.lvl_set = wr_ok && (addr_i == AW'(OFF_SET));
    wr_o.lvl_clr = wr_ok && (addr_i == AW'(OFF_CLR));
    wr_o.dir     = wr_ok && (addr_i == AW'(OFF_DIR));
    wr_o.gp      = wr_ok && (addr_i == AW'(OFF_GP));
  end

  always_comb begin
    if (addr_i == AW'(OFF_LVL))      rd_o = RD_LVL;
    else if (addr_i == AW'(OFF_DIR)) rd_o = RD_DIR;
    else if (addr_i == AW'(OFF_GP))  rd_o = RD_GP;
    else                             rd_o = RD_ZERO;
  end
endmodule

// File: rtl/gpio_sc_core.sv
module gpio_sc_core
  import gpio_sc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  wr_sel_t       wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] lvl_o,
  output logic [DW-1:0] dir_o,
  output logic [DW-1:0] gp_o,
  output logic          err_o
);
  logic hits_out;
  logic strobe;
  assign hits_out = |(dir_o & wdata_i);
  assign strobe   = wr_i.lvl_set | wr_i.lvl_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o <= '0;
    end else if (strobe && hits_out) begin
      if (wr_i.lvl_set) lvl_o <= lvl_o | wdata_i;
      else              lvl_o <= lvl_o & ~wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_o <= '0;
    else if (wr_i.dir) dir_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gp_o <= '0;
    else if (wr_i.gp) gp_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 err_o <= 1'b0;
    else if (strobe && !hits_out) err_o <= 1'b1;
  end
endmodule

// File: rtl/gpio_sc_rdmux.sv
module gpio_sc_rdmux
  import gpio_sc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  rd_src_e       sel_i,
  input  logic [DW-1:0] lvl_i,
  input  logic [DW-1:0] dir_i,
  input  logic [DW-1:0] gp_i,
  output logic [DW-1:0] rdata_o
);
  always_comb begin
    unique case (sel_i)
      RD_LVL:  rdata_o = lvl_i;
      RD_DIR:  rdata_o = dir_i;
      RD_GP:   rdata_o = gp_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_setclr_regs.sv
module gpio_setclr_regs
  import gpio_sc_pkg::*;
#(
  parameter int unsigned AW    = 12,
  parameter int unsigned DW    = 32,
  parameter int unsigned IRQ_N = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [DW/8-1:0]  be_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [DW-1:0]    pin_o,
  output logic [DW-1:0]    dir_o,
  output logic             err_o,
  output logic [IRQ_N-1:0] irq_o
);
  localparam int unsigned BW = DW / 8;

  wr_sel_t       wr_sel;
  rd_src_e       rd_sel;
  logic [DW-1:0] lvl_q, dir_q, gp_q;

  gpio_sc_decode #(.AW(AW), .BW(BW)) i_decode (
    .req_i  (req_i),
    .we_i   (we_i),
    .be_i   (be_i),
    .addr_i (addr_i),
    .wr_o   (wr_sel),
    .rd_o   (rd_sel)
  );

  gpio_sc_core #(.DW(DW)) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_sel),
    .wdata_i (wdata_i),
    .lvl_o   (lvl_q),
    .dir_o   (dir_q),
    .gp_o    (gp_q),
    .err_o   (err_o)
  );

  gpio_sc_rdmux #(.DW(DW)) i_rdmux (
    .sel_i   (rd_sel),
    .lvl_i   (lvl_q),
    .dir_i   (dir_q),
    .gp_i    (gp_q),
    .rdata_o (rdata_o)
  );

  assign pin_o = lvl_q;
  assign dir_o = dir_q;
  assign irq_o = '0; // interrupt generation not implemented
endmodule

// File: rtl/gpio_sc_chk.sv
module gpio_sc_chk
  import gpio_sc_pkg::*;
#(
  parameter int unsigned AW    = 12,
  parameter int unsigned DW    = 32,
  parameter int unsigned IRQ_N = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [DW/8-1:0]  be_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic [DW-1:0]    pin_o,
  input logic [DW-1:0]    dir_o,
  input logic             err_o,
  input logic [IRQ_N-1:0] irq_o
);
  logic full_wr, set_wr, clr_wr, hits;
  assign full_wr = req_i && we_i && (&be_i);
  assign set_wr  = full_wr && (addr_i == AW'(OFF_SET));
  assign clr_wr  = full_wr && (addr_i == AW'(OFF_CLR));
  assign hits    = |(dir_o & wdata_i);

  AST_SET_ORS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr && hits |=> pin_o == ($past(pin_o) | $past(wdata_i))); // R3

  AST_CLR_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && hits |=> pin_o == ($past(pin_o) & ~$past(wdata_i))); // R4

  AST_DROP_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_wr || clr_wr) && !hits |=> $stable(pin_o) && err_o); // R5

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R5

  AST_PARTIAL_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && !(&be_i) |=> $stable(pin_o) && $stable(dir_o)); // R9

  AST_DIR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && addr_i == AW'(OFF_DIR) |-> rdata_o == dir_o); // R2

  AST_LVL_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && addr_i == AW'(OFF_LVL) |-> rdata_o == pin_o); // R11

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == '0); // R10
endmodule

bind gpio_setclr_regs gpio_sc_chk #(.AW(AW), .DW(DW), .IRQ_N(IRQ_N)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .be_i    (be_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pin_o   (pin_o),
  .dir_o   (dir_o),
  .err_o   (err_o),
  .irq_o   (irq_o)
);

// File: tb/test_gpio_setclr_regs.sv
`timescale 1ns/1ps
module test_gpio_setclr_regs;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int IRQ_N = 9;
  localparam int NV = 26;
  localparam int VW = 86;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] be = 4'h0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, pin, dir;
  logic err;
  logic [IRQ_N-1:0] irq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_setclr_regs #(.AW(AW), .DW(DW), .IRQ_N(IRQ_N)) i_gpio_setclr_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .be_i(be),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pin_o(pin),
    .dir_o(dir), .err_o(err), .irq_o(irq)
  );

  // {we, be, addr, data, expect (rdata on read, pin after write), err, req}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 4'hF, 12'h004, 32'h0,        32'h0,        1'b0, 4'd1},  // R1
    {1'b1, 4'hF, 12'h004, 32'h000000FF, 32'h0,        1'b0, 4'd2},  // R2
    {1'b0, 4'hF, 12'h004, 32'h0,        32'h000000FF, 1'b0, 4'd2},  // R2
    {1'b1, 4'hF, 12'h008, 32'h00000F01, 32'h00000F01, 1'b0, 4'd3},  // R3
    {1'b0, 4'hF, 12'h000, 32'h0,        32'h00000F01, 1'b0, 4'd11}, // R11
    {1'b1, 4'hF, 12'h00C, 32'h00000100, 32'h00000F01, 1'b1, 4'd5},  // R5
    {1'b1, 4'hF, 12'h00C, 32'h00000301, 32'h00000C00, 1'b1, 4'd4},  // R4
    {1'b1, 4'hF, 12'h008, 32'hFF000000, 32'h00000C00, 1'b1, 4'd5},  // R5
    {1'b1, 4'hF, 12'h010, 32'hFFFFFFFF, 32'h00000C00, 1'b1, 4'd6},  // R6
    {1'b1, 4'hF, 12'h014, 32'hFFFFFFFF, 32'h00000C00, 1'b1, 4'd6},  // R6
    {1'b1, 4'hF, 12'h018, 32'hFFFFFFFF, 32'h00000C00, 1'b1, 4'd6},  // R6
    {1'b0, 4'hF, 12'h010, 32'h0,        32'h0,        1'b1, 4'd6},  // R6
    {1'b0, 4'hF, 12'h018, 32'h0,        32'h0,        1'b1, 4'd6},  // R6
    {1'b0, 4'hF, 12'h004, 32'h0,        32'h000000FF, 1'b1, 4'd6},  // R6
    {1'b1, 4'hF, 12'h020, 32'hDEADBEEF, 32'h00000C00, 1'b1, 4'd7},  // R7
    {1'b0, 4'hF, 12'h020, 32'h0,        32'hDEADBEEF, 1'b1, 4'd7},  // R7
    {1'b1, 4'hF, 12'h000, 32'h00001234, 32'h00000C00, 1'b1, 4'd8},  // R8
    {1'b1, 4'hF, 12'h040, 32'h00000055, 32'h00000C00, 1'b1, 4'd8},  // R8
    {1'b0, 4'hF, 12'h040, 32'h0,        32'h0,        1'b1, 4'd8},  // R8
    {1'b0, 4'hF, 12'h024, 32'h0,        32'h0,        1'b1, 4'd8},  // R8
    {1'b1, 4'h3, 12'h008, 32'h000000F0, 32'h00000C00, 1'b1, 4'd9},  // R9
    {1'b1, 4'h1, 12'h004, 32'h0,        32'h00000C00, 1'b1, 4'd9},  // R9
    {1'b0, 4'hF, 12'h004, 32'h0,        32'h000000FF, 1'b1, 4'd9},  // R9
    {1'b1, 4'hF, 12'h008, 32'h000000F0, 32'h00000CF0, 1'b1, 4'd3},  // R3
    {1'b0, 4'hF, 12'h00C, 32'h0,        32'h0,        1'b1, 4'd6},  // R6
    {1'b0, 4'hF, 12'h000, 32'h0,        32'h00000CF0, 1'b1, 4'd11}  // R11
  };

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                       input int rq, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // drive one access; reads are sampled before the edge, writes after it
  task automatic access(input logic w, input logic [3:0] b, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] rd);
    @(negedge clk);
    req = 1'b1; we = w; be = b; addr = a; wdata = d;
    #1 rd = rdata;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] rd;
    repeat (3) @(negedge clk);
    check(pin, 32'h0, 1, "pin at reset");                        // R1
    check({31'b0, err}, 32'h0, 1, "err at reset");               // R1
    check({{(DW-IRQ_N){1'b0}}, irq}, 32'h0, 10, "irq at reset"); // R10
    rst_n = 1'b1;
    access(1'b0, 4'hF, 12'h020, 32'h0, rd);
    check(rd, 32'h0, 1, "gp at reset");                          // R1

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      access(v[85], v[84:81], v[80:69], v[68:37], rd);
      if (v[85]) check(pin, v[36:5], int'(v[3:0]), $sformatf("vec %0d pin", i));
      else       check(rd,  v[36:5], int'(v[3:0]), $sformatf("vec %0d rdata", i));
      check({31'b0, err}, {31'b0, v[4]}, int'(v[3:0]), $sformatf("vec %0d err", i));
      check({{(DW-IRQ_N){1'b0}}, irq}, 32'h0, 10, "irq quiet"); // R10
    end

    // reset clears everything again (R1)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check(pin, 32'h0, 1, "pin after reset");
    check({31'b0, err}, 32'h0, 1, "err after reset");
    access(1'b0, 4'hF, 12'h004, 32'h0, rd);
    check(rd, 32'h0, 1, "dir after reset");
    access(1'b0, 4'hF, 12'h020, 32'h0, rd);
    check(rd, 32'h0, 1, "gp after reset");

    // R9: partial-byte dropped-type strobe must not raise err
    access(1'b1, 4'h7, 12'h008, 32'h1, rd);
    check({31'b0, err}, 32'h0, 9, "err after partial strobe");
    check(pin, 32'h0, 9, "pin after partial strobe");
    // R5: with all pins input, a full set write is dropped and flags
    access(1'b1, 4'hF, 12'h008, 32'h1, rd);
    check({31'b0, err}, 32'h1, 5, "err after dropped set");
    check(pin, 32'h0, 5, "pin after dropped set");
    repeat (3) @(negedge clk);
    check({31'b0, err}, 32'h1, 5, "err sticky");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule